// File: doc/BRIEF.md
# Byte-Laned Asynchronous SRAM Access Controller

This block sits between a clocked requester and an external asynchronous static RAM. The RAM is 32 bits wide with a 19-bit word address. It has one active-low select per byte lane, one active-low write strobe and one active-low read strobe. The requester presents a single-cycle request while the controller shows ready. A request carries an address, a read/write flag, four byte-lane strobes and write data. The controller then plays out a timed access on the RAM pins. Every analog limit of the RAM is a nanosecond parameter, and it is turned into a whole number of clock cycles by rounding up against the clock period parameter.

Reads assert the read strobe for a fixed number of cycles. The word is captured on the edge that ends that count, and a one-cycle valid pulse comes back with it. Writes run in three phases: address and data set up, the write strobe pulse, and a recovery phase in which the data is still driven. The controller drives the shared data lines only during the write phases. When a write follows a read, it waits an extra turn-around count so that the RAM has released the bus before the controller's drivers switch on.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, reqReady is 1, memCeN is 4'hF, memWeN, memOeN are 1, memDoe is 0 and rdValid is 0.
- R2: During a read the RAM address equals the request address, memOeN is 0, and memCeN[i] is 0 exactly for the lanes with reqByteEn[i]=1. Lane i is data bits 8i+7..8i.
- R3: rdValid is a one-cycle pulse. It rises RD_CYC = max(1, ceil(max(tRC, tAA, tOE)/tCLK)) clock edges after the accepting edge. rdData holds the RAM word in enabled lanes and zero in disabled lanes.
- R4: A write keeps memWeN low for exactly PULSE_CYC = max(1, ceil(tWP/tCLK), ceil(tAW/tCLK)-SETUP_CYC, ceil(tDW/tCLK)-SETUP_CYC) cycles. It changes only the enabled lanes of the addressed word, and a write with no lane enabled changes nothing.
- R5: The controller drives memDout (memDoe=1) only during a write access. This takes SETUP_CYC + PULSE_CYC + RECOV_CYC cycles, with SETUP_CYC = max(1, ceil(tAS/tCLK)) and RECOV_CYC = max(1, ceil(tWC/tCLK) - SETUP_CYC - PULSE_CYC). memDoe is never 1 while memOeN is 0.
- R6: After memOeN rises, memDoe stays 0 for at least TURN_CYC = max(1, ceil(tHZ/tCLK)) cycles.
- R7: reqReady is 1 only when no access is in progress. A request raised while reqReady is 0 is ignored and has no effect on the RAM.
- R8: memWeN rises while memDoe is still 1, so the write data is held past the end of the write strobe.
- R9: memAddr stays unchanged for as long as any lane select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Word address |
| reqByteEn | input | 4 | Lane strobes, bit i selects bits 8i+7..8i |
| reqWdata | input | 32 | Write data |
| reqReady | output | 1 | Controller idle, request accepted this cycle |
| rdValid | output | 1 | One-cycle pulse with read data |
| rdData | output | 32 | Captured read word, disabled lanes zero |
| memAddr | output | 19 | RAM word address |
| memCeN | output | 4 | Active-low per-lane selects |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low read strobe |
| memDout | output | 32 | Data toward the RAM |
| memDoe | output | 1 | Enable for the controller's data drivers |
| memDin | input | 32 | Data from the RAM |

## Verification
Two events can fall in the same cycle. One is the RAM giving up the bus after a read, and the other is the controller accepting the next write and preparing to drive. The bench provokes this by sending writes straight after reads, in random and directed order. The RAM model records the instant its outputs turn off and flags any driver enable that comes inside the release window or overlaps the RAM's drive. A second overlap is a request raised while a write is in flight. This is judged by reading back the poked address later and finding its old contents.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_HOLD,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURNAROUND
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // register a new request
    logic capture;  // sample read data, raise valid
    logic laneOn;   // assert selects of enabled lanes
    logic oeOn;     // assert read strobe
    logic weOn;     // assert write strobe
    logic driveOn;  // enable controller data drivers
  } ctrlStrobe_t;

  function automatic int ceilCycles(int ns, int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int RD_CYC    = 3,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int RECOV_CYC = 1,
  parameter int TURN_CYC  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);

  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, SETUP_CYC),
                                 maxOf(maxOf(PULSE_CYC, RECOV_CYC), TURN_CYC));
  localparam int CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t RD_LD    = cnt_t'(RD_CYC - 1);
  localparam cnt_t SETUP_LD = cnt_t'(SETUP_CYC - 1);
  localparam cnt_t PULSE_LD = cnt_t'(PULSE_CYC - 1);
  localparam cnt_t RECOV_LD = cnt_t'(RECOV_CYC - 1);
  localparam cnt_t TURN_LD  = cnt_t'(TURN_CYC - 1);

  ctrlState_t state, stateNx;
  cnt_t       cnt, cntNx;
  logic       recentRead, recentReadNx;
  logic       loadNow, captureNow;
  logic       cntDone;

  assign cntDone = (cnt == '0);

  always_comb begin
    stateNx      = state;
    cntNx        = cnt;
    recentReadNx = recentRead;
    loadNow      = 1'b0;
    captureNow   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          loadNow = 1'b1;
          if (!reqWrite) begin
            stateNx = ST_RD_ACCESS;
            cntNx   = RD_LD;
          end else if (recentRead) begin
            stateNx = ST_TURNAROUND;
            cntNx   = TURN_LD;
          end else begin
            stateNx = ST_WR_SETUP;
            cntNx   = SETUP_LD;
          end
        end
      end
      ST_RD_ACCESS: begin
        if (cntDone) begin
          captureNow = 1'b1;
          stateNx    = ST_RD_HOLD;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      ST_RD_HOLD: begin
        recentReadNx = 1'b1;
        stateNx      = ST_IDLE;
      end
      ST_TURNAROUND: begin
        if (cntDone) begin
          recentReadNx = 1'b0;
          stateNx      = ST_WR_SETUP;
          cntNx        = SETUP_LD;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      ST_WR_SETUP: begin
        if (cntDone) begin
          stateNx = ST_WR_PULSE;
          cntNx   = PULSE_LD;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      ST_WR_PULSE: begin
        if (cntDone) begin
          stateNx = ST_WR_RECOVER;
          cntNx   = RECOV_LD;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      ST_WR_RECOVER: begin
        if (cntDone) begin
          stateNx = ST_IDLE;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      recentRead <= 1'b0;
    end else begin
      state      <= stateNx;
      cnt        <= cntNx;
      recentRead <= recentReadNx;
    end
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobe         = '0;
    strobe.load    = loadNow;
    strobe.capture = captureNow;
    strobe.laneOn  = state inside {ST_RD_ACCESS, ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOVER};
    strobe.oeOn    = (state == ST_RD_ACCESS);
    strobe.weOn    = (state == ST_WR_PULSE);
    strobe.driveOn = state inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOVER};
  end

endmodule

// File: rtl/sram_lane_dpath.sv
module sram_lane_dpath
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [LANES-1:0]          reqByteEn,
  input  logic [LANES*LANE_W-1:0]   reqWdata,
  input  logic [LANES*LANE_W-1:0]   memDin,
  output logic                      rdValid,
  output logic [LANES*LANE_W-1:0]   rdData,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [LANES-1:0]          memCeN,
  output logic                      memWeN,
  output logic                      memOeN,
  output logic [LANES*LANE_W-1:0]   memDout,
  output logic                      memDoe
);

  localparam int DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  laneQ;
  logic [DATA_W-1:0] wdataQ;
  logic              validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      laneQ  <= '0;
      wdataQ <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobe.capture;
      if (strobe.load) begin
        addrQ  <= reqAddr;
        laneQ  <= reqByteEn;
        wdataQ <= reqWdata;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneData;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneData <= '0;
      end else if (strobe.capture) begin
        laneData <= laneQ[g] ? memDin[g*LANE_W +: LANE_W] : '0;
      end
    end

    assign rdData[g*LANE_W +: LANE_W] = laneData;
    assign memCeN[g] = ~(strobe.laneOn & laneQ[g]);
  end

  assign rdValid = validQ;
  assign memAddr = addrQ;
  assign memWeN  = ~strobe.weOn;
  assign memOeN  = ~strobe.oeOn;
  assign memDout = wdataQ;
  assign memDoe  = strobe.driveOn;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 32,
  parameter int CLK_NS  = 5,
  parameter int T_RC_NS = 15,
  parameter int T_AA_NS = 15,
  parameter int T_OE_NS = 7,
  parameter int T_WC_NS = 15,
  parameter int T_WP_NS = 10,
  parameter int T_AW_NS = 10,
  parameter int T_AS_NS = 0,
  parameter int T_DW_NS = 7,
  parameter int T_HZ_NS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W/8-1:0] reqByteEn,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W/8-1:0] memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  input  logic [DATA_W-1:0] memDin
);

  localparam int LANE_W    = 8;
  localparam int LANES     = DATA_W / LANE_W;
  localparam int RD_CYC    = maxOf(1, ceilCycles(maxOf(maxOf(T_RC_NS, T_AA_NS), T_OE_NS), CLK_NS));
  localparam int SETUP_CYC = maxOf(1, ceilCycles(T_AS_NS, CLK_NS));
  localparam int PULSE_CYC = maxOf(maxOf(1, ceilCycles(T_WP_NS, CLK_NS)),
                                   maxOf(ceilCycles(T_AW_NS, CLK_NS) - SETUP_CYC,
                                         ceilCycles(T_DW_NS, CLK_NS) - SETUP_CYC));
  localparam int RECOV_CYC = maxOf(1, ceilCycles(T_WC_NS, CLK_NS) - SETUP_CYC - PULSE_CYC);
  localparam int TURN_CYC  = maxOf(1, ceilCycles(T_HZ_NS, CLK_NS));

  ctrlStrobe_t strobe;

  sram_lane_fsm #(
    .RD_CYC   (RD_CYC),
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .RECOV_CYC(RECOV_CYC),
    .TURN_CYC (TURN_CYC)
  ) uFsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  sram_lane_dpath #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqByteEn(reqByteEn),
    .reqWdata (reqWdata),
    .memDin   (memDin),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .memAddr  (memAddr),
    .memCeN   (memCeN),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memDout  (memDout),
    .memDoe   (memDoe)
  );

endmodule

// File: rtl/sram_lane_checker.sv
module sram_lane_checker #(
  parameter int ADDR_W    = 19,
  parameter int LANES     = 4,
  parameter int PULSE_CYC = 2,
  parameter int TURN_CYC  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [LANES-1:0]  memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDoe
);

  localparam logic [7:0] SAT = 8'hFF;

  logic [7:0] weLowCnt;
  logic [7:0] oeHighCnt;
  logic       anyLane;

  assign anyLane = (memCeN != '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weLowCnt  <= '0;
      oeHighCnt <= 8'(TURN_CYC);
    end else begin
      if (!memWeN) weLowCnt <= (weLowCnt == SAT) ? SAT : weLowCnt + 8'd1;
      else         weLowCnt <= '0;
      if (memOeN)  oeHighCnt <= (oeHighCnt == SAT) ? SAT : oeHighCnt + 8'd1;
      else         oeHighCnt <= '0;
    end
  end

  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt >= 8'(PULSE_CYC))); // R4

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    !(memDoe && !memOeN)); // R5

  AST_WE_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDoe); // R5

  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDoe) |-> (oeHighCnt >= 8'(TURN_CYC))); // R6

  AST_RDVALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R3

  AST_READY_IDLE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!anyLane && !memDoe && memWeN && memOeN)); // R7

  AST_DATA_HELD_AFTER_WE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> memDoe); // R8

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (anyLane && $past(anyLane)) |-> $stable(memAddr)); // R9

endmodule

bind sram_lane_ctrl sram_lane_checker #(
  .ADDR_W   (ADDR_W),
  .LANES    (LANES),
  .PULSE_CYC(PULSE_CYC),
  .TURN_CYC (TURN_CYC)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .rdValid (rdValid),
  .memAddr (memAddr),
  .memCeN  (memCeN),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .memDoe  (memDoe)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_model #(
  parameter int T_WP_NS = 10,
  parameter int T_DW_NS = 7,
  parameter int T_AW_NS = 10,
  parameter int T_HZ_NS = 7
) (
  input  logic [18:0] addr,
  input  logic [3:0]  ceN,
  input  logic        weN,
  input  logic        oeN,
  input  logic [31:0] busIn,
  input  logic        busOe,
  output logic [31:0] busOut,
  output int          violations
);
  logic [31:0] store [int];
  time  tWeFall, tAddr, tData, tRamOff;
  logic weArmed;
  logic ramDrive;

  initial begin
    violations = 0;
    tWeFall = 0; tAddr = 0; tData = 0; tRamOff = 0;
    weArmed = 1'b0;
  end

  assign ramDrive = (ceN != 4'hF) && !oeN && weN;

  function automatic logic [31:0] peek(logic [18:0] a);
    return store.exists(int'(a)) ? store[int'(a)] : 32'h0;
  endfunction

  always @(addr) tAddr = $time;
  always @(busIn) tData = $time;
  always @(negedge ramDrive) tRamOff = $time;
  always @(negedge weN) begin
    tWeFall = $time;
    weArmed = 1'b1;
  end

  always @(posedge weN) begin
    if (weArmed) begin
      logic [31:0] cur;
      if ($time - tWeFall < time'(T_WP_NS)) begin violations++; $display("model: write pulse short"); end
      if ($time - tData   < time'(T_DW_NS)) begin violations++; $display("model: data setup short"); end
      if ($time - tAddr   < time'(T_AW_NS)) begin violations++; $display("model: address valid short"); end
      if (!busOe) begin violations++; $display("model: data released before strobe end"); end
      cur = peek(addr);
      for (int i = 0; i < 4; i++) if (!ceN[i]) cur[i*8 +: 8] = busIn[i*8 +: 8];
      store[int'(addr)] = cur;
      weArmed = 1'b0;
    end
  end

  always @(posedge busOe) begin
    if ($time - tRamOff < time'(T_HZ_NS)) begin violations++; $display("model: drivers on inside release window"); end
  end

  always @(busOe or ramDrive) begin
    if (busOe && ramDrive) begin violations++; $display("model: bus contention"); end
  end

  always @(addr or ceN or oeN or weN) begin
    logic [31:0] cur;
    cur = peek(addr);
    for (int i = 0; i < 4; i++)
      busOut[i*8 +: 8] = (!ceN[i] && !oeN && weN) ? cur[i*8 +: 8] : 8'hxx;
  end
endmodule

module sram_lane_ctrl_test;
  localparam int CLK_NS = 8;

  function automatic int cdiv(int n, int d); return (n + d - 1) / d; endfunction
  function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

  localparam int EXP_RD    = mx(1, cdiv(15, CLK_NS));
  localparam int EXP_SETUP = mx(1, cdiv(0, CLK_NS));
  localparam int EXP_PULSE = mx(mx(1, cdiv(10, CLK_NS)), mx(cdiv(10, CLK_NS) - EXP_SETUP, cdiv(7, CLK_NS) - EXP_SETUP));
  localparam int EXP_RECOV = mx(1, cdiv(15, CLK_NS) - EXP_SETUP - EXP_PULSE);
  localparam int EXP_TURN  = mx(1, cdiv(7, CLK_NS));

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [3:0]  reqByteEn = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, rdValid, memWeN, memOeN, memDoe;
  logic [31:0] rdData, memDout, memDin;
  logic [18:0] memAddr;
  logic [3:0]  memCeN;
  int          violations;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] shadow [int];

  always #(CLK_NS/2) clk = ~clk;

  sram_lane_ctrl #(.CLK_NS(CLK_NS)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .reqWdata(reqWdata),
    .reqReady(reqReady), .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memDout(memDout), .memDoe(memDoe), .memDin(memDin)
  );

  sram_lane_model uRam (
    .addr(memAddr), .ceN(memCeN), .weN(memWeN), .oeN(memOeN),
    .busIn(memDout), .busOe(memDoe), .busOut(memDin), .violations(violations)
  );

  task automatic check(string req, logic ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // release window monitor: R6
  int  sinceOe = 100;
  logic prevDoe = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memDoe && !prevDoe)
        check("R6 turnaround", sinceOe >= EXP_TURN, sinceOe, EXP_TURN);
      if (!memOeN) sinceOe = 0;
      else if (sinceOe < 100) sinceOe++;
      prevDoe = memDoe;
    end
  end

  function automatic logic [31:0] expWord(logic [18:0] a, logic [3:0] be);
    logic [31:0] w;
    w = shadow.exists(int'(a)) ? shadow[int'(a)] : 32'h0;
    for (int i = 0; i < 4; i++) if (!be[i]) w[i*8 +: 8] = 8'h00;
    return w;
  endfunction

  task automatic issue(logic w, logic [18:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqByteEn = be; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doRead(logic [18:0] a, logic [3:0] be);
    int n;
    issue(1'b0, a, be, 32'h0);
    check("R2 lane selects", memCeN == ~be && !memOeN && memAddr == a, {28'h0, memCeN}, {28'h0, ~be});
    n = 0;
    while (!rdValid && n < 20) begin @(negedge clk); n++; end
    check("R3 read latency", n == EXP_RD, n, EXP_RD);
    check("R3 read data", rdData == expWord(a, be), rdData, expWord(a, be));
    @(negedge clk);
    check("R3 valid pulse width", !rdValid, {31'h0, rdValid}, 32'h0);
  endtask

  task automatic doWrite(logic [18:0] a, logic [3:0] be, logic [31:0] d,
                         logic poke, logic [18:0] pokeA);
    int doeCnt, weCnt;
    logic bad;
    logic [31:0] cur;
    doeCnt = 0; weCnt = 0; bad = 1'b0;
    issue(1'b1, a, be, d);
    if (poke) begin
      check("R7 ready low while busy", !reqReady, {31'h0, reqReady}, 32'h0);
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = pokeA; reqByteEn = 4'hF; reqWdata = ~d;
    end
    while (!reqReady) begin
      if (memDoe) begin
        doeCnt++;
        if (memCeN != ~be || memDout != d || memAddr != a) bad = 1'b1;
      end
      if (!memWeN) begin
        weCnt++;
        if (!memDoe) bad = 1'b1;
      end
      @(negedge clk);
      reqValid = 1'b0;
    end
    check("R4 write pulse cycles", weCnt == EXP_PULSE, weCnt, EXP_PULSE);
    check("R5 drive cycles", doeCnt == EXP_SETUP + EXP_PULSE + EXP_RECOV, doeCnt, EXP_SETUP + EXP_PULSE + EXP_RECOV);
    check("R9 write pins steady", !bad, {31'h0, bad}, 32'h0);
    cur = shadow.exists(int'(a)) ? shadow[int'(a)] : 32'h0;
    for (int i = 0; i < 4; i++) if (be[i]) cur[i*8 +: 8] = d[i*8 +: 8];
    shadow[int'(a)] = cur;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset pins", reqReady && memCeN == 4'hF && memWeN && memOeN && !memDoe && !rdValid,
          {26'h0, reqReady, memCeN, memWeN}, {26'h0, 1'b1, 4'hF, 1'b1});
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", reqReady && memCeN == 4'hF && !memDoe && !rdValid,
          {27'h0, reqReady, memCeN}, {27'h0, 1'b1, 4'hF});

    // directed corners
    doWrite(19'h00010, 4'hF, 32'hA1B2C3D4, 1'b0, '0);
    doRead (19'h00010, 4'hF);
    doWrite(19'h00010, 4'b0101, 32'h11223344, 1'b0, '0);   // R4 partial lanes
    doRead (19'h00010, 4'hF);
    doWrite(19'h00010, 4'h0, 32'hFFFFFFFF, 1'b0, '0);      // R4 no lane
    doRead (19'h00010, 4'hF);
    doRead (19'h00010, 4'b1010);                            // R3 masked lanes
    doRead (19'h00010, 4'h0);
    doWrite(19'h7FFFF, 4'hF, 32'hDEADBEEF, 1'b0, '0);       // top address
    doRead (19'h7FFFF, 4'hF);
    doWrite(19'h00020, 4'hF, 32'h5A5A5A5A, 1'b1, 19'h00030); // R7 poke ignored
    doRead (19'h00030, 4'hF);
    doRead (19'h00020, 4'hF);

    // random mix
    for (int i = 0; i < 120; i++) begin
      logic [18:0] a;
      logic [3:0]  be;
      a  = 19'($urandom_range(0, 7)) | (($urandom_range(0, 1) == 1) ? 19'h7FFF8 : 19'h0);
      be = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) doWrite(a, be, $urandom, 1'b0, '0);
      else                           doRead(a, be);
    end
    for (int k = 0; k < 16; k++)
      doRead((k < 8) ? 19'(k) : (19'h7FFF8 | 19'(k - 8)), 4'hF);

    repeat (4) @(negedge clk);
    check("R4 R6 model timing", violations == 0, violations, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule